// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Interrupt-on-Change

This core is the register and pin logic of a two-bank, sixteen-pin general-purpose I/O port. Each pin has a direction bit, an input inversion bit, a pull-up enable and an output latch. Any pin can be set up to raise an interrupt in one of two ways: on any change of its input, or for as long as its input differs from a per-pin reference bit. A host reaches the registers through a plain synchronous byte port. A write strobe updates a register on the clock edge. A read strobe returns the data one cycle later with `rvalid`. The serial framing that sits in front of the core is not part of it.

Every register has one byte per bank. A byte address is the register index shifted left by one, ORed with the bank bit. Bank A uses even addresses and bank B uses odd ones, so a 16-bit little-endian access with a stride of two maps straight onto this layout. Each bank keeps its own pending interrupt, a one-hot flag byte and a capture byte. The pending interrupt clears on a read of that bank's port register, or on a read of its capture register, depending on a configuration bit. The two interrupt output pins can be set to active high or active low, push-pull or open-drain, and can be mirrored onto each other. The register access port has no back-pressure: the core accepts every strobe in the cycle it is presented. The port therefore has no ready signal, and a read always answers exactly one cycle later.

Top module: `gpx_core`

## Requirements
- R1: After reset every pin is an input: `pin_oe` is 0 and a read of either direction register returns 0xFF. All other writable registers read 0. With the reset configuration, both interrupt pins drive their inactive level, which is high.
- R2: Byte address = {index[3:0], bank}, with bank 0 = A. The index values are: 0 direction (1 = input), 1 input inversion, 2 interrupt enable, 3 reference value, 4 compare select, 5 configuration, 6 pull-up, 7 flag, 8 capture, 9 port, 10 output latch. A read strobe returns its data with `rvalid` high on the following cycle.
- R3: For each pin, `pin_oe` is the inverse of its direction bit, `pin_out` is its output-latch bit and `pin_pullup` is its pull-up bit.
- R4: A port read returns, for an input pin, the synchronized pin value XOR its inversion bit, and for an output pin its latch bit. A write to the port address updates the output latch.
- R5: With its compare-select bit at 0, an enabled input pin raises its bank's interrupt when its (inverted) value changes.
- R6: With its compare-select bit at 1, an enabled input pin raises its bank's interrupt while its value differs from its reference bit. The interrupt re-asserts right after a clear for as long as the mismatch persists.
- R7: When several pins of one bank trigger in the same cycle, the flag byte holds only the lowest-numbered of them. The capture byte takes that bank's port value at that moment. The other bank's flag and capture bytes do not change.
- R8: While a bank's interrupt is pending, further triggers leave its flag and capture bytes unchanged.
- R9: With configuration bit 0 at 0, a read of a bank's port register clears that bank's interrupt and a capture read does not. With bit 0 at 1 the roles are swapped. A clear zeroes the flag byte and keeps the capture byte.
- R10: The configuration register is shared by both banks: a write to address 0x0A or 0x0B updates it, and a read of either address returns it.
- R11: Configuration bit 1 = 1 makes the interrupt pins active high, and 0 makes them active low. With bit 2 at 0 the pins are push-pull, with `irq_oe` high on both.
- R12: With configuration bit 2 at 1 (open-drain), `irq_o` is 0 and `irq_oe` is high only while the interrupt is asserted.
- R13: With configuration bit 6 at 1, both interrupt pins assert when either bank has a pending interrupt.
- R14: A pin raises no interrupt if it is an output or if its interrupt enable is 0. Toggling such a pin leaves the interrupt pins and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address {index, bank} |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| pin_in | input | 16 | Pad input values, asynchronous |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| pin_pullup | output | 16 | Pad pull-up enables |
| irq_o | output | 2 | Interrupt pin values, bit 0 = bank A |
| irq_oe | output | 2 | Interrupt pin output enables |

## Verification
The following rules are checked on every cycle:
- each flag byte stays one-hot or zero;
- a flag byte is non-zero exactly while its bank is pending;
- a pending bank keeps its flag and its pending state until a read of its clearing address;
- read data arrives one cycle after the strobe;
- open-drain mode never drives a high level;
- push-pull mode always enables both pins;
- mirroring keeps the two pins identical.

Only the directed scenarios can show the rest. These are: which pin wins when several change together, the captured byte values, the re-assertion of a compare-mode interrupt that still mismatches, the swap of the clearing read, the port read mixing inputs with latch bits, and the absence of interrupts from output or disabled pins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int NUM_BANKS = 2;
  localparam int IDX_W     = 4;

  localparam logic [IDX_W-1:0] RI_DIR  = 4'd0;
  localparam logic [IDX_W-1:0] RI_INV  = 4'd1;
  localparam logic [IDX_W-1:0] RI_IEN  = 4'd2;
  localparam logic [IDX_W-1:0] RI_REF  = 4'd3;
  localparam logic [IDX_W-1:0] RI_CMP  = 4'd4;
  localparam logic [IDX_W-1:0] RI_CFG  = 4'd5;
  localparam logic [IDX_W-1:0] RI_PUP  = 4'd6;
  localparam logic [IDX_W-1:0] RI_FLAG = 4'd7;
  localparam logic [IDX_W-1:0] RI_CAP  = 4'd8;
  localparam logic [IDX_W-1:0] RI_PORT = 4'd9;
  localparam logic [IDX_W-1:0] RI_LAT  = 4'd10;

  // configuration bit positions
  localparam int CB_CLR_CAP = 0;
  localparam int CB_POL_HI  = 1;
  localparam int CB_ODRAIN  = 2;
  localparam int CB_MIRROR  = 6;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_val,
  input  logic             clr_on_cap,
  output logic [W-1:0]     rd_val,
  output logic             pend,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     lat_o,
  output logic [W-1:0]     pup_o,
  output logic [W-1:0]     flag_o
);
  logic [W-1:0] dir_q, inv_q, ien_q, ref_q, cmp_q, pup_q, lat_q;
  logic [W-1:0] flag_q, cap_q, prev_q;
  logic         pend_q;
  logic [W-1:0] in_val, port_val, trig, first;
  logic         clr;

  assign in_val   = pin_val ^ inv_q;
  assign port_val = (dir_q & in_val) | (~dir_q & lat_q);
  assign trig     = ien_q & dir_q &
                    ((cmp_q & (in_val ^ ref_q)) | (~cmp_q & (in_val ^ prev_q)));
  assign first    = trig & (~trig + 1'b1);
  assign clr      = rd_stb && (idx == (clr_on_cap ? RI_CAP : RI_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      inv_q <= '0;
      ien_q <= '0;
      ref_q <= '0;
      cmp_q <= '0;
      pup_q <= '0;
      lat_q <= '0;
    end else if (wr_stb) begin
      case (idx)
        RI_DIR:           dir_q <= wdata;
        RI_INV:           inv_q <= wdata;
        RI_IEN:           ien_q <= wdata;
        RI_REF:           ref_q <= wdata;
        RI_CMP:           cmp_q <= wdata;
        RI_PUP:           pup_q <= wdata;
        RI_PORT, RI_LAT:  lat_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= in_val;
      if ((|trig) && (!pend_q || clr)) begin
        pend_q <= 1'b1;
        flag_q <= first;
        cap_q  <= port_val;
      end else if (clr) begin
        pend_q <= 1'b0;
        flag_q <= '0;
      end
    end
  end

  always_comb begin
    case (idx)
      RI_DIR:  rd_val = dir_q;
      RI_INV:  rd_val = inv_q;
      RI_IEN:  rd_val = ien_q;
      RI_REF:  rd_val = ref_q;
      RI_CMP:  rd_val = cmp_q;
      RI_PUP:  rd_val = pup_q;
      RI_FLAG: rd_val = flag_q;
      RI_CAP:  rd_val = cap_q;
      RI_PORT: rd_val = port_val;
      RI_LAT:  rd_val = lat_q;
      default: rd_val = '0;
    endcase
  end

  assign pend   = pend_q;
  assign dir_o  = dir_q;
  assign lat_o  = lat_q;
  assign pup_o  = pup_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/gpx_irq_out.sv
module gpx_irq_out #(
  parameter int NB = 2
) (
  input  logic [NB-1:0] pend,
  input  logic          mirror,
  input  logic          pol_hi,
  input  logic          odrain,
  output logic [NB-1:0] irq_o,
  output logic [NB-1:0] irq_oe
);
  logic any_pend;
  assign any_pend = |pend;

  for (genvar b = 0; b < NB; b++) begin : g_pin
    logic act;
    assign act       = mirror ? any_pend : pend[b];
    assign irq_o[b]  = odrain ? 1'b0 : (pol_hi ? act : ~act);
    assign irq_oe[b] = odrain ? act : 1'b1;
  end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int PINS_PER_BANK = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int NPINS        = NUM_BANKS * PINS_PER_BANK,
  localparam int AW           = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [PINS_PER_BANK-1:0] wdata,
  output logic [PINS_PER_BANK-1:0] rdata,
  output logic                     rvalid,
  input  logic [NPINS-1:0]         pin_in,
  output logic [NPINS-1:0]         pin_out,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NPINS-1:0]         pin_pullup,
  output logic [NUM_BANKS-1:0]     irq_o,
  output logic [NUM_BANKS-1:0]     irq_oe
);
  logic [IDX_W-1:0]         idx;
  logic                     bsel;
  logic [PINS_PER_BANK-1:0] cfg_q;
  logic [NPINS-1:0]         pin_sync;
  logic [NPINS-1:0]         flag_w;
  logic [NUM_BANKS-1:0]     pend_w;
  logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0] bank_rd;
  logic [PINS_PER_BANK-1:0] rd_mux;

  assign idx  = addr[AW-1:1];
  assign bsel = addr[0];

  gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cfg_q <= '0;
    else if (wr_en && idx == RI_CFG)   cfg_q <= wdata;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * PINS_PER_BANK;
    logic [PINS_PER_BANK-1:0] dir_b;
    gpx_bank #(.W(PINS_PER_BANK)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_en && (bsel == 1'(b))),
      .rd_stb     (rd_en && (bsel == 1'(b))),
      .idx        (idx),
      .wdata      (wdata),
      .pin_val    (pin_sync[LO +: PINS_PER_BANK]),
      .clr_on_cap (cfg_q[CB_CLR_CAP]),
      .rd_val     (bank_rd[b]),
      .pend       (pend_w[b]),
      .dir_o      (dir_b),
      .lat_o      (pin_out[LO +: PINS_PER_BANK]),
      .pup_o      (pin_pullup[LO +: PINS_PER_BANK]),
      .flag_o     (flag_w[LO +: PINS_PER_BANK])
    );
    assign pin_oe[LO +: PINS_PER_BANK] = ~dir_b;
  end

  assign rd_mux = (idx == RI_CFG) ? cfg_q : bank_rd[bsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  gpx_irq_out #(.NB(NUM_BANKS)) u_irq (
    .pend   (pend_w),
    .mirror (cfg_q[CB_MIRROR]),
    .pol_hi (cfg_q[CB_POL_HI]),
    .odrain (cfg_q[CB_ODRAIN]),
    .irq_o  (irq_o),
    .irq_oe (irq_oe)
  );
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [4:0]  addr,
  input logic [7:0]  cfg,
  input logic [1:0]  pend,
  input logic [15:0] flags,
  input logic        rvalid,
  input logic [1:0]  irq_o,
  input logic [1:0]  irq_oe
);
  logic [3:0] clr_idx;
  logic       clr_a, clr_b;
  assign clr_idx = cfg[0] ? 4'd8 : 4'd9;
  assign clr_a   = rd_en && addr == {clr_idx, 1'b0};
  assign clr_b   = rd_en && addr == {clr_idx, 1'b1};

  assert_flag_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[7:0]) && $onehot0(flags[15:8]));

  assert_flag_tracks_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] == (flags[7:0] != 8'h00)) && (pend[1] == (flags[15:8] != 8'h00)));

  assert_hold_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] && !clr_a |=> pend[0] && $stable(flags[7:0]));

  assert_hold_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend[1] && !clr_b |=> pend[1] && $stable(flags[15:8]));

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  assert_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  assert_push_pull_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[2] |-> irq_oe == 2'b11);

  assert_open_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[2] |-> irq_o == 2'b00);

  assert_mirror_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[6] |-> (irq_o[0] == irq_o[1]) && (irq_oe[0] == irq_oe[1]));
endmodule

bind gpx_core gpx_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_en  (rd_en),
  .addr   (addr),
  .cfg    (cfg_q),
  .pend   (pend_w),
  .flags  (flag_w),
  .rvalid (rvalid),
  .irq_o  (irq_o),
  .irq_oe (irq_oe)
);

// File: tb/gpx_core_test.sv
`timescale 1ns/1ps
module gpx_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_pullup;
  logic [1:0]  irq_o, irq_oe;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  gpx_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R2 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h00, v); chk("R1 dir A", v, 8'hFF);
    rd(5'h01, v); chk("R1 dir B", v, 8'hFF);
    rd(5'h05, v); chk("R1 ien B", v, 8'h00);
    rd(5'h0A, v); chk("R1 cfg", v, 8'h00);
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 pin_out", pin_out, 16'h0000);
    chk("R1 pullup", pin_pullup, 16'h0000);
    chk("R1 R11 irq idle", {irq_oe, irq_o}, 4'b1111);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    wr(5'h00, 8'h0F);
    wr(5'h14, 8'hA5);
    wr(5'h0D, 8'h3C);
    chk("R3 pin_oe", pin_oe[7:0], 8'hF0);
    chk("R3 pin_out", pin_out[7:0], 8'hA5);
    chk("R3 pullup", pin_pullup[15:8], 8'h3C);
    pin_in[7:0] = 8'h33; settle();
    rd(5'h12, v); chk("R4 port mix", v, 8'hA3);
    wr(5'h02, 8'h01);
    rd(5'h12, v); chk("R4 port invert", v, 8'hA2);
    wr(5'h12, 8'h5A);
    chk("R4 port write to latch", pin_out[7:0], 8'h5A);
    wr(5'h02, 8'h00); wr(5'h00, 8'hFF);
    pin_in[7:0] = 8'h00; settle();
  endtask

  task automatic t_change();
    logic [7:0] v;
    wr(5'h05, 8'hFF);
    pin_in[10] = 1'b1; settle();
    chk("R5 irq B asserted", irq_o, 2'b01);
    rd(5'h0F, v); chk("R5 flag B", v, 8'h04);
    rd(5'h11, v); chk("R5 cap B", v, 8'h04);
    chk("R9 cap read no clear", irq_o, 2'b01);
    pin_in[11] = 1'b1; settle();
    rd(5'h0F, v); chk("R8 flag held", v, 8'h04);
    rd(5'h11, v); chk("R8 cap held", v, 8'h04);
    rd(5'h13, v); chk("R4 port B", v, 8'h0C);
    chk("R9 port read clears", irq_o, 2'b11);
    rd(5'h0F, v); chk("R9 flag cleared", v, 8'h00);
    rd(5'h11, v); chk("R9 cap kept", v, 8'h04);
  endtask

  task automatic t_multi();
    logic [7:0] v;
    pin_in[14:13] = 2'b11; settle();
    rd(5'h0F, v); chk("R7 lowest flag", v, 8'h20);
    rd(5'h11, v); chk("R7 capture", v, 8'h6C);
    rd(5'h0E, v); chk("R7 other bank flag", v, 8'h00);
    rd(5'h13, v);
    chk("R9 clear multi", irq_o, 2'b11);
  endtask

  task automatic t_compare();
    logic [7:0] v;
    wr(5'h08, 8'h01); wr(5'h06, 8'h00); wr(5'h04, 8'h01);
    settle();
    chk("R6 match no irq", irq_o, 2'b11);
    pin_in[0] = 1'b1; settle();
    chk("R6 mismatch irq", irq_o, 2'b10);
    rd(5'h12, v);
    chk("R6 reasserts", irq_o, 2'b10);
    pin_in[0] = 1'b0; settle();
    chk("R6 still latched", irq_o, 2'b10);
    rd(5'h12, v);
    chk("R6 clears on match", irq_o, 2'b11);
    wr(5'h08, 8'h00);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(5'h00, 8'hFD); wr(5'h04, 8'h02);
    pin_in[2:1] = 2'b11; settle();
    chk("R14 no irq", irq_o, 2'b11);
    rd(5'h0E, v); chk("R14 flag A zero", v, 8'h00);
    pin_in[2:1] = 2'b00; settle();
    wr(5'h00, 8'hFF); wr(5'h04, 8'h01);
    settle();
  endtask

  task automatic t_clr_cap();
    logic [7:0] v;
    wr(5'h0A, 8'h01);
    rd(5'h0B, v); chk("R10 cfg alias", v, 8'h01);
    pin_in[0] = 1'b1; settle();
    chk("R9 irq A", irq_o, 2'b10);
    rd(5'h12, v); chk("R4 port A", v, 8'h01);
    chk("R9 port read no clear", irq_o, 2'b10);
    rd(5'h10, v); chk("R9 cap A", v, 8'h01);
    chk("R9 cap read clears", irq_o, 2'b11);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    wr(5'h0B, 8'h02);
    chk("R11 active high idle", {irq_oe, irq_o}, 4'b1100);
    pin_in[8] = 1'b1; settle();
    chk("R11 active high B", irq_o, 2'b10);
    wr(5'h0B, 8'h42);
    chk("R13 mirror", irq_o, 2'b11);
    wr(5'h0A, 8'h46);
    chk("R12 od mirror", {irq_oe, irq_o}, 4'b1100);
    wr(5'h0A, 8'h04);
    chk("R12 od B only", {irq_oe, irq_o}, 4'b1000);
    rd(5'h13, v); chk("R4 port B final", v, 8'h6D);
    chk("R12 od released", irq_oe, 2'b00);
    rd(5'h0B, v); chk("R10 cfg readback", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pins();
    t_change();
    t_multi();
    t_compare();
    t_ignore();
    t_clr_cap();
    t_modes();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule